// File: doc/BRIEF.md
# Wave Slot and Vector Register Allocator

This block admits waves onto one SIMD. It has two limited resources: a fixed number of wave slots and a vector register file shared by every resident wave. A launch request gives a lane mode (32 or 64 lanes) and a per-lane register count. In the same cycle the block either grants the wave a slot and a contiguous block of the register file, or refuses it. A refused request leaves no state behind. A release names a slot, which frees that wave's slot and its register block on the next clock edge.

Register space is counted in wave32 registers, each 128 bytes wide, so the default 128 KB file holds 1024 of them. Space is handed out in granules of 8. A per-lane count is rounded up to whole granules, and a 64-lane wave takes twice the rounded amount. A separate combinational query returns how many waves of a given shape could be resident at once. That number is the smaller of the slot count and the number of such register blocks that fit in the whole file.

Top module: `wave_slot_alloc`

## Requirements
- R1: After reset no wave is live, `free_regs` reads 1024 and `release_err` is low.
- R2: A granted wave holds ceil(count/8)*8 registers for 32 lanes and twice that for 64 lanes. `free_regs` falls by that amount on the cycle after the grant.
- R3: A launch is granted, in the cycle it is presented, when a free slot and a free contiguous register range both exist. The slot is the lowest-numbered free slot. `grant_base` is the lowest address in wave32 registers of a free range of the needed size, and it is always a multiple of 8.
- R4: A launch is refused in the cycle it is presented when all 16 slots are live, when no contiguous range is large enough, or when the count is 0. A refused launch changes no slot and no register.
- R5: A release of a live slot frees that slot and returns its registers on the next cycle, and the freed range can be granted again.
- R6: A release of a slot that is not live changes nothing, and `release_err` is high for exactly the following cycle.
- R7: `query_limit` equals min(16, floor(1024 / (ceil(count/8)*8 * f))), where f is 1 for 32 lanes and 2 for 64 lanes. A count of 0 gives 16. For example, 64 registers at 32 lanes gives 16, 96 at 32 lanes gives 10, and 128 at 64 lanes gives 4.
- R8: When a launch and a release arrive in the same cycle, the launch is decided on the state before the release, and both take effect at the clock edge.
- R9: `live_waves` equals the number of live slots, one cycle after each grant or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_valid | input | 1 | Launch request present |
| launch_wave64 | input | 1 | 1 = 64-lane wave, 0 = 32-lane wave |
| launch_vgprs | input | 8 | Registers per lane requested |
| launch_grant | output | 1 | Request accepted this cycle |
| launch_refuse | output | 1 | Request rejected this cycle |
| grant_slot | output | 4 | Slot given to the wave (valid with grant) |
| grant_base | output | 10 | First register of the block, in wave32 registers (valid with grant) |
| release_valid | input | 1 | Release request present |
| release_slot | input | 4 | Slot to free |
| release_err | output | 1 | Previous cycle released a slot that was not live |
| live_waves | output | 5 | Number of live slots |
| free_regs | output | 11 | Free wave32 registers |
| query_wave64 | input | 1 | Lane mode for the occupancy query |
| query_vgprs | input | 8 | Per-lane count for the occupancy query |
| query_limit | output | 5 | Maximum resident waves of that shape |

## Verification
`launch_grant`, `launch_refuse`, `grant_slot`, `grant_base` and `query_limit` are combinational and due in the same cycle as their inputs. `live_waves`, `free_regs` and `release_err` change on the edge that follows the stimulus. The bench drives each cycle's inputs just after the falling edge. A few time units later it compares the combinational outputs with its reference model, which has not yet been advanced. It advances the model only after the rising edge, so the registered outputs are compared with the updated model one cycle later, at the next comparison point.

// File: rtl/wavealloc_pkg.sv
package wavealloc_pkg;

  // Lane mode of a wave; selects the register storage multiplier.
  typedef enum logic {
    LANES32 = 1'b0,
    LANES64 = 1'b1
  } lanes_e;

endpackage

// File: rtl/wa_need.sv
// Converts a per-lane register count into register granules, doubled for
// 64-lane waves.
module wa_need #(
  parameter int VGPR_W = 8,
  parameter int GRAN   = 8,
  parameter int NW     = 7
) (
  input  logic [VGPR_W-1:0]         vgprs,
  input  wavealloc_pkg::lanes_e     lanes,
  output logic [NW-1:0]             need
);
  import wavealloc_pkg::*;

  localparam int GSH = $clog2(GRAN);
  localparam int PW  = VGPR_W + 1;

  logic [PW-1:0] padded;
  logic [NW-1:0] per_lane;

  always_comb begin
    padded   = {1'b0, vgprs} + PW'(GRAN - 1);
    per_lane = NW'(padded >> GSH);
    if (lanes == LANES64) need = NW'({per_lane, 1'b0});
    else                  need = per_lane;
  end

endmodule

// File: rtl/wa_occupancy.sv
// Occupancy limit: the smaller of the slot count and the number of blocks of
// the given size that fit in the whole register file.
module wa_occupancy #(
  parameter int NUM_SLOTS = 16,
  parameter int NG        = 128,
  parameter int NW        = 7,
  parameter int CW        = 5
) (
  input  logic [NW-1:0] need,
  output logic [CW-1:0] limit
);
  localparam int RW = $clog2(NG + 1);
  localparam int XW = (RW > NW) ? RW : NW;

  logic [XW-1:0] quot;

  always_comb begin
    quot = '0;
    if (need != '0) quot = XW'(NG) / XW'(need);
    if (need == '0 || quot >= XW'(NUM_SLOTS)) limit = CW'(NUM_SLOTS);
    else                                      limit = CW'(quot);
  end

endmodule

// File: rtl/wa_slot_table.sv
// Wave slot bookkeeping: live bits, per-slot register block, lowest free slot.
module wa_slot_table #(
  parameter int NUM_SLOTS = 16,
  parameter int GW        = 7,
  parameter int NW        = 7,
  parameter int SW        = 4,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [GW-1:0] alloc_base,
  input  logic [NW-1:0] alloc_size,
  input  logic          rel_valid,
  input  logic [SW-1:0] rel_slot,
  output logic          slot_found,
  output logic [SW-1:0] free_slot,
  output logic [CW-1:0] live_cnt,
  output logic          rel_hit,
  output logic [GW-1:0] rel_base,
  output logic [NW-1:0] rel_size,
  output logic          rel_err
);

  logic [NUM_SLOTS-1:0] live_q, live_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 err_q, err_d;
  logic [GW-1:0]        base_q [NUM_SLOTS];
  logic [NW-1:0]        size_q [NUM_SLOTS];
  logic                 rel_live;

  // Lowest-numbered free slot.
  always_comb begin
    slot_found = 1'b0;
    free_slot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!live_q[i]) begin
        slot_found = 1'b1;
        free_slot  = SW'(i);
      end
    end
  end

  always_comb begin
    rel_live = (int'(rel_slot) < NUM_SLOTS) && live_q[rel_slot];
    rel_hit  = rel_valid && rel_live;
    rel_base = base_q[rel_slot];
    rel_size = size_q[rel_slot];
  end

  // Next state.
  always_comb begin
    live_d = live_q;
    if (alloc_en) live_d[free_slot] = 1'b1;
    if (rel_hit)  live_d[rel_slot]  = 1'b0;
    cnt_d = cnt_q;
    if (alloc_en && !rel_hit) cnt_d = cnt_q + CW'(1);
    if (!alloc_en && rel_hit) cnt_d = cnt_q - CW'(1);
    err_d = rel_valid && !rel_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (alloc_en || rel_hit) begin
        live_q <= live_d;
        cnt_q  <= cnt_d;
      end
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else if (alloc_en) begin
      base_q[free_slot] <= alloc_base;
      size_q[free_slot] <= alloc_size;
    end
  end

  assign live_cnt = cnt_q;
  assign rel_err  = err_q;

  p_count_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(live_q)));

  p_grant_sets_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> live_q[$past(free_slot)]);

  p_release_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |=> !live_q[$past(rel_slot)]);

  p_bad_release_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_live && !alloc_en) |=> (live_q == $past(live_q)));

endmodule

// File: rtl/wa_reg_map.sv
// Register file occupancy map in granules with first-fit contiguous search.
module wa_reg_map #(
  parameter int NG = 128,
  parameter int GW = 7,
  parameter int NW = 7,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] need,
  input  logic          alloc_en,
  input  logic          rel_en,
  input  logic [GW-1:0] rel_base,
  input  logic [NW-1:0] rel_size,
  output logic          fit_found,
  output logic [GW-1:0] fit_base,
  output logic [RW-1:0] free_cnt
);
  localparam int XW = ((RW > NW) ? RW : NW) + 1;

  logic [NG-1:0] free_q, free_d;
  logic [RW-1:0] cnt_q, cnt_d;
  logic [XW-1:0] run;
  logic [GW-1:0] fit_end;
  logic [XW-1:0] alloc_hi, rel_hi;

  // Length of the free run ending at each granule; first run long enough wins.
  always_comb begin
    run       = '0;
    fit_found = 1'b0;
    fit_end   = '0;
    for (int i = 0; i < NG; i++) begin
      if (free_q[i]) run = run + XW'(1);
      else           run = '0;
      if (!fit_found && need != '0 && run >= XW'(need)) begin
        fit_found = 1'b1;
        fit_end   = GW'(i);
      end
    end
  end

  always_comb begin
    fit_base = GW'(XW'(fit_end) + XW'(1) - XW'(need));
    alloc_hi = XW'(fit_base) + XW'(need);
    rel_hi   = XW'(rel_base) + XW'(rel_size);
  end

  for (genvar g = 0; g < NG; g++) begin : g_gran
    logic take, give;
    assign take = alloc_en && (XW'(g) >= XW'(fit_base)) && (XW'(g) < alloc_hi);
    assign give = rel_en   && (XW'(g) >= XW'(rel_base)) && (XW'(g) < rel_hi);
    assign free_d[g] = (free_q[g] | give) & ~take;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (alloc_en) cnt_d = cnt_d - RW'(need);
    if (rel_en)   cnt_d = cnt_d + RW'(rel_size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '1;
      cnt_q  <= RW'(NG);
    end else if (alloc_en || rel_en) begin
      free_q <= free_d;
      cnt_q  <= cnt_d;
    end
  end

  assign free_cnt = cnt_q;

  p_count_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == RW'($countones(free_q)));

  p_fit_is_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fit_found |-> (free_q[fit_base] && free_q[fit_end]));

  p_release_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> free_q[$past(rel_base)]);

endmodule

// File: rtl/wave_slot_alloc.sv
// Wave slot and vector register allocator for one SIMD.
module wave_slot_alloc #(
  parameter int NUM_SLOTS = 16,
  parameter int RF_REGS   = 1024,
  parameter int GRAN      = 8,
  parameter int VGPR_W    = 8,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int AW = $clog2(RF_REGS),
  localparam int FW = $clog2(RF_REGS + 1),
  localparam int CW = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic              launch_wave64,
  input  logic [VGPR_W-1:0] launch_vgprs,
  output logic              launch_grant,
  output logic              launch_refuse,
  output logic [SW-1:0]     grant_slot,
  output logic [AW-1:0]     grant_base,
  input  logic              release_valid,
  input  logic [SW-1:0]     release_slot,
  output logic              release_err,
  output logic [CW-1:0]     live_waves,
  output logic [FW-1:0]     free_regs,
  input  logic              query_wave64,
  input  logic [VGPR_W-1:0] query_vgprs,
  output logic [CW-1:0]     query_limit
);
  import wavealloc_pkg::*;

  localparam int NG   = RF_REGS / GRAN;
  localparam int GW   = $clog2(NG);
  localparam int RW   = $clog2(NG + 1);
  localparam int GSH  = $clog2(GRAN);
  localparam int MAXG = ((1 << VGPR_W) - 1 + GRAN - 1) / GRAN;
  localparam int NW   = $clog2(2 * MAXG + 1);

  logic [NW-1:0] launch_need, query_need;
  logic          slot_found, fit_found, alloc_en, rel_hit;
  logic [SW-1:0] free_slot;
  logic [GW-1:0] fit_base, rel_base;
  logic [NW-1:0] rel_size;
  logic [RW-1:0] free_gran;

  wa_need #(.VGPR_W(VGPR_W), .GRAN(GRAN), .NW(NW)) u_launch_need (
    .vgprs (launch_vgprs),
    .lanes (lanes_e'(launch_wave64)),
    .need  (launch_need)
  );

  wa_need #(.VGPR_W(VGPR_W), .GRAN(GRAN), .NW(NW)) u_query_need (
    .vgprs (query_vgprs),
    .lanes (lanes_e'(query_wave64)),
    .need  (query_need)
  );

  wa_slot_table #(.NUM_SLOTS(NUM_SLOTS), .GW(GW), .NW(NW), .SW(SW), .CW(CW)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .alloc_base (fit_base),
    .alloc_size (launch_need),
    .rel_valid  (release_valid),
    .rel_slot   (release_slot),
    .slot_found (slot_found),
    .free_slot  (free_slot),
    .live_cnt   (live_waves),
    .rel_hit    (rel_hit),
    .rel_base   (rel_base),
    .rel_size   (rel_size),
    .rel_err    (release_err)
  );

  wa_reg_map #(.NG(NG), .GW(GW), .NW(NW), .RW(RW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .need      (launch_need),
    .alloc_en  (alloc_en),
    .rel_en    (rel_hit),
    .rel_base  (rel_base),
    .rel_size  (rel_size),
    .fit_found (fit_found),
    .fit_base  (fit_base),
    .free_cnt  (free_gran)
  );

  wa_occupancy #(.NUM_SLOTS(NUM_SLOTS), .NG(NG), .NW(NW), .CW(CW)) u_occ (
    .need  (query_need),
    .limit (query_limit)
  );

  // Grant needs both resources at once; otherwise refuse with no side effect.
  always_comb begin
    alloc_en      = launch_valid && slot_found && fit_found;
    launch_grant  = alloc_en;
    launch_refuse = launch_valid && !alloc_en;
    grant_slot    = free_slot;
    grant_base    = AW'({fit_base, {GSH{1'b0}}});
    free_regs     = FW'({free_gran, {GSH{1'b0}}});
  end

  p_one_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> (launch_grant != launch_refuse));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_valid |-> (!launch_grant && !launch_refuse));

  p_full_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && live_waves == CW'(NUM_SLOTS)) |-> launch_refuse);

  p_refuse_keeps_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_refuse && !release_valid) |=> $stable(free_regs));

  p_limit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (query_limit != '0) && (query_limit <= CW'(NUM_SLOTS)));

endmodule

// File: tb/sim_wave_slot_alloc.sv
module sim_wave_slot_alloc;
  localparam int NS = 16;
  localparam int RF = 1024;
  localparam int GR = 8;
  localparam int NG = RF / GR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       launch_valid, launch_wave64, launch_grant, launch_refuse;
  logic [7:0] launch_vgprs;
  logic [3:0] grant_slot;
  logic [9:0] grant_base;
  logic       release_valid, release_err;
  logic [3:0] release_slot;
  logic [4:0] live_waves, query_limit;
  logic [10:0] free_regs;
  logic       query_wave64;
  logic [7:0] query_vgprs;

  always #5 clk = ~clk;

  wave_slot_alloc u0 (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_wave64(launch_wave64), .launch_vgprs(launch_vgprs),
    .launch_grant(launch_grant), .launch_refuse(launch_refuse),
    .grant_slot(grant_slot), .grant_base(grant_base),
    .release_valid(release_valid), .release_slot(release_slot), .release_err(release_err),
    .live_waves(live_waves), .free_regs(free_regs),
    .query_wave64(query_wave64), .query_vgprs(query_vgprs), .query_limit(query_limit)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state (granule units for addresses and sizes).
  bit m_live [NS];
  int m_base [NS];
  int m_size [NS];
  bit m_free [NG];
  bit m_err;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gran_need(bit w64, int v);
    int per = (v + GR - 1) / GR;
    return w64 ? 2 * per : per;
  endfunction

  function automatic int first_fit(int need);
    if (need == 0) return -1;
    for (int s = 0; s + need <= NG; s++) begin
      bit ok = 1;
      for (int k = 0; k < need; k++) if (!m_free[s + k]) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic int exp_limit(bit w64, int v);
    int n = gran_need(w64, v);
    int q;
    if (n == 0) return NS;
    q = NG / n;
    return (q < NS) ? q : NS;
  endfunction

  task automatic step(string req, bit lv, bit lw, int lg, bit rv, int rs, bit qw, int qg);
    int need, es, eb, ec, ef;
    bit eg, hit;
    @(negedge clk);
    launch_valid  = lv;
    launch_wave64 = lw;
    launch_vgprs  = 8'(lg);
    release_valid = rv;
    release_slot  = 4'(rs);
    query_wave64  = qw;
    query_vgprs   = 8'(qg);
    #2;
    need = gran_need(lw, lg);
    es = -1;
    for (int i = NS - 1; i >= 0; i--) if (!m_live[i]) es = i;
    eb = first_fit(need);
    eg = lv && (need > 0) && (es >= 0) && (eb >= 0);
    check(req, "launch_grant", int'(launch_grant), int'(eg));
    check(req, "launch_refuse", int'(launch_refuse), int'(lv && !eg));
    if (eg) begin
      check(req, "grant_slot", int'(grant_slot), es);
      check(req, "grant_base", int'(grant_base), eb * GR);
    end
    ec = 0;
    for (int i = 0; i < NS; i++) ec += m_live[i];
    ef = 0;
    for (int i = 0; i < NG; i++) ef += m_free[i];
    check("R9", "live_waves", int'(live_waves), ec);
    check("R2", "free_regs", int'(free_regs), ef * GR);
    check("R6", "release_err", int'(release_err), int'(m_err));
    check("R7", "query_limit", int'(query_limit), exp_limit(qw, qg));
    @(posedge clk);
    // R8: release and launch both apply; launch was judged on old state.
    hit   = rv && m_live[rs];
    m_err = rv && !m_live[rs];
    if (hit) begin
      m_live[rs] = 0;
      for (int k = 0; k < m_size[rs]; k++) m_free[m_base[rs] + k] = 1;
    end
    if (eg) begin
      m_live[es] = 1;
      m_base[es] = eb;
      m_size[es] = need;
      for (int k = 0; k < need; k++) m_free[eb + k] = 0;
    end
  endtask

  task automatic qlit(bit qw, int qg, int exp);
    @(negedge clk);
    launch_valid = 0; release_valid = 0;
    query_wave64 = qw; query_vgprs = 8'(qg);
    #2;
    check("R7", "query_limit literal", int'(query_limit), exp);
    @(posedge clk);
    m_err = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int dummy;
    launch_valid = 0; launch_wave64 = 0; launch_vgprs = 0;
    release_valid = 0; release_slot = 0; query_wave64 = 0; query_vgprs = 0;
    for (int i = 0; i < NS; i++) begin m_live[i] = 0; m_base[i] = 0; m_size[i] = 0; end
    for (int i = 0; i < NG; i++) m_free[i] = 1;
    m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1", "live_waves", int'(live_waves), 0);
    check("R1", "free_regs", int'(free_regs), RF);
    check("R1", "release_err", int'(release_err), 0);
    check("R1", "launch_grant", int'(launch_grant), 0);

    // R3: fill every slot with 64-register 32-lane waves (file exactly full)
    for (int i = 0; i < NS; i++) step("R3", 1, 0, 64, 0, 0, 0, 64);
    // R4: no slot and no space
    step("R4", 1, 0, 8, 0, 0, 0, 96);
    // R5: release slot 3, then R6: release it again while not live
    step("R5", 0, 0, 0, 1, 3, 1, 128);
    step("R6", 0, 0, 0, 1, 3, 0, 0);
    // R4: slot free but hole of 64 is too small for 96
    step("R4", 1, 0, 96, 0, 0, 0, 1);
    // R2: 33 rounds to 40, lands in the hole at 192
    step("R2", 1, 0, 33, 0, 0, 1, 255);
    // R4: slots exhausted again
    step("R4", 1, 0, 1, 0, 0, 0, 8);
    // R8: launch with simultaneous release is refused on pre-release state
    step("R8", 1, 1, 12, 1, 5, 1, 12);
    // R8: same launch now fits in slot 5's freed range
    step("R8", 1, 1, 12, 0, 0, 0, 0);
    // R4: zero-register launch refused
    step("R4", 1, 0, 0, 0, 0, 0, 0);
    // R5: release everything
    for (int s = 0; s < NS; s++) step("R5", 0, 0, 0, 1, s, 0, 64);

    // R7: literal occupancy values
    qlit(0, 64, 16);
    qlit(0, 96, 10);
    qlit(1, 128, 4);
    qlit(1, 96, 5);
    qlit(0, 0, 16);

    // R3/R5: four 64-lane 128-register waves fill the file; reuse a hole
    for (int i = 0; i < 4; i++) step("R3", 1, 1, 128, 0, 0, 1, 128);
    step("R4", 1, 0, 8, 0, 0, 0, 8);
    step("R5", 0, 0, 0, 1, 1, 0, 8);
    step("R5", 1, 0, 255, 0, 0, 0, 255);
    for (int s = 0; s < NS; s++) step("R5", 0, 0, 0, 1, s, 0, 64);

    // R3: mixed traffic
    dummy = $urandom(7);
    for (int n = 0; n < 3000; n++) begin
      bit lv = ($urandom % 2) == 0;
      bit rv = ($urandom % 5) < 2;
      step("R3", lv, 1'($urandom % 2), int'($urandom % 130), rv, int'($urandom % NS),
           1'($urandom % 2), int'($urandom % 256));
    end
    for (int s = 0; s < NS; s++) step("R5", 0, 0, 0, 1, s, 0, 64);

    // R7: full query sweep
    for (int w = 0; w < 2; w++)
      for (int v = 0; v < 256; v++) step("R7", 0, 0, 0, 0, 0, 1'(w), v);

    finished = 1;
    summary();
    $finish;
  end

endmodule